// File: doc/BRIEF.md
# DMA Completion Event Ring Writer

This block keeps the pointer state of one DMA channel: a circular ring of transfer descriptors that software fills, and a circular ring of completion event records that the block fills. Software posts descriptors in memory and then writes the new descriptor write offset to a transfer doorbell. A downstream transfer engine sees that descriptors are waiting and reads the byte offset of the oldest one. When it finishes that descriptor, it presents a done pulse with a completion code, a 4-bit error-info value and the descriptor's config word.

For each accepted completion the block emits one 16-byte event record on its record write port, in descriptor order. It then advances both the descriptor read offset and the event write offset. Software returns processed event slots by writing an event read offset to a second doorbell. The block never lets the event write offset catch up with the event read offset. While that would happen, it holds back new completions. A sticky end-of-block interrupt flag is raised for completed descriptors that asked for it.

Top module: `dma_evt_ring_writer`

## Requirements
- R1: After reset, all four ring offsets read 0, the descriptor ring length reads DESC_BYTES*TX_SLOTS (256), the event ring length reads 16*EV_SLOTS (128), `doneReady` is 0 and `eobIrq` is 0.
- R2: A register write to address 0x400 sets the descriptor write offset (read at 0x004) only if the value is a multiple of DESC_BYTES and below the descriptor ring length. Any other value is ignored.
- R3: `doneReady` is 1 exactly when the descriptor read offset (read at 0x000, also driven on `descOffset`) differs from the descriptor write offset, the event ring is not full, and no ring-length write is presented in the same cycle. A `doneValid` pulse while `doneReady` is 0 produces no record and changes no offset.
- R4: In the cycle of an accepted completion, `evWrEn` is 1 and `evWrData` carries four 32-bit words. Word 0 (bits 31:0) holds the code in 31:28, the error info in 27:24, zero in 23:16 and config bits 15:0 in 15:0 (channel index in 15:8, transfer type in 7:0, where 3 means copy and 4 means fill). Word 1 holds the descriptor offset. Word 2 holds the full config word. Word 3 is zero. The code is passed through unchanged: 1 means success and 4 means error.
- R5: `evWrAddr` equals the event write offset (read at 0x008). Each accepted completion advances it by 16, and it becomes 0 when the sum reaches the event ring length. The descriptor read offset advances by DESC_BYTES and wraps the same way at the descriptor ring length.
- R6: Word 1 of the Nth record equals the offset of the Nth descriptor consumed, so records follow descriptor order.
- R7: When advancing the event write offset would make it equal the event read offset, `doneReady` is 0 and completions are held off, even though descriptors are pending.
- R8: A write to 0x404 sets the event read offset (read at 0x00C) only if the value is a multiple of 16 and below the event ring length; otherwise it is ignored. It may coincide with an accepted completion, and both take effect.
- R9: `eobIrq` (also read at 0x020 bit 0) is set by an accepted completion whose config bit 16 is 1. A completion with bit 16 clear leaves it unchanged. Writing 1 in bit 0 to 0x024 clears it, and a set in the same cycle wins over the clear.
- R10: A write to 0x010 (descriptor ring) or 0x014 (event ring) sets that ring's length and clears both of its offsets. The value must be a multiple of the ring's entry size and at least two entries; otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| doneValid | input | 1 | Transfer engine finished the oldest pending descriptor |
| doneCode | input | 4 | Completion code (1 success, 4 error) |
| doneErrInfo | input | 4 | Error-info nibble |
| doneCfg | input | 32 | Config word of the finished descriptor |
| doneReady | output | 1 | A completion is accepted in this cycle if `doneValid` is 1 |
| descOffset | output | OFF_W | Byte offset of the oldest pending descriptor |
| evWrEn | output | 1 | Event record write strobe |
| evWrAddr | output | OFF_W | Byte offset of the record in the event ring |
| evWrData | output | 128 | Event record, word 0 in the low 32 bits |
| eobIrq | output | 1 | Sticky end-of-block interrupt |

## Verification
Several functions can fall into one cycle. An accepted completion can meet an event doorbell write, which tests that the write offset advances and the read offset loads together. It can meet an interrupt clear, which tests that the set wins. It can meet a ring-length write, which tests that the completion is refused. The bench provokes each case by driving `doneValid` and a register write on the same clock edge. It then judges the result by reading back every offset and the interrupt flag against a model built from the requirements. A separate stall case fills the event ring while descriptors remain pending. It checks that a done pulse there produces no record, and that freeing one slot reopens the path on the next cycle.

// File: rtl/evr_pkg.sv
package evr_pkg;

  localparam int REG_AW = 12;
  localparam int EVT_BYTES = 16;
  localparam int EVT_LG = 4;

  localparam logic [REG_AW-1:0] A_TX_RD   = 12'h000;
  localparam logic [REG_AW-1:0] A_TX_WR   = 12'h004;
  localparam logic [REG_AW-1:0] A_EV_WR   = 12'h008;
  localparam logic [REG_AW-1:0] A_EV_RD   = 12'h00C;
  localparam logic [REG_AW-1:0] A_TX_LEN  = 12'h010;
  localparam logic [REG_AW-1:0] A_EV_LEN  = 12'h014;
  localparam logic [REG_AW-1:0] A_IRQ     = 12'h020;
  localparam logic [REG_AW-1:0] A_IRQ_CLR = 12'h024;
  localparam logic [REG_AW-1:0] A_TX_BELL = 12'h400;
  localparam logic [REG_AW-1:0] A_EV_BELL = 12'h404;

  // control-to-datapath strobes
  typedef struct packed {
    logic setTxLen;
    logic setEvLen;
    logic txBell;
    logic evBell;
    logic irqClr;
    logic complete;
  } evr_strobe_t;

endpackage

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrBit0,
  input  logic              doneValid,
  input  logic              txPending,
  input  logic              evFull,
  output logic              doneReady,
  output evr_strobe_t       strb
);

  logic lenWrite;

  always_comb begin
    lenWrite = regWrEn && ((regAddr == A_TX_LEN) || (regAddr == A_EV_LEN));
    // a ring-length write resets pointers, so no completion may share its cycle
    doneReady = txPending && !evFull && !lenWrite;

    strb.setTxLen = regWrEn && (regAddr == A_TX_LEN);
    strb.setEvLen = regWrEn && (regAddr == A_EV_LEN);
    strb.txBell   = regWrEn && (regAddr == A_TX_BELL);
    strb.evBell   = regWrEn && (regAddr == A_EV_BELL);
    strb.irqClr   = regWrEn && (regAddr == A_IRQ_CLR) && regWrBit0;
    strb.complete = doneValid && doneReady;
  end

endmodule

// File: rtl/evr_datapath.sv
module evr_datapath
  import evr_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int DESC_BYTES = 32,
  parameter int TX_LEN_RST = 256,
  parameter int EV_LEN_RST = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  evr_strobe_t       strb,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [3:0]        doneCode,
  input  logic [3:0]        doneErrInfo,
  input  logic [31:0]       doneCfg,
  output logic [OFF_W-1:0]  txRdOff,
  output logic [OFF_W-1:0]  txWrOff,
  output logic [OFF_W-1:0]  evWrOff,
  output logic [OFF_W-1:0]  evRdOff,
  output logic [OFF_W-1:0]  evLen,
  output logic              txPending,
  output logic              evFull,
  output logic              eobIrq,
  output logic              evWrEn,
  output logic [OFF_W-1:0]  evWrAddr,
  output logic [127:0]      evWrData,
  output logic [31:0]       regRdData
);

  localparam int DESC_LG = $clog2(DESC_BYTES);
  localparam int PAD = 32 - OFF_W;
  localparam logic [OFF_W-1:0] DESC_STEP = OFF_W'(DESC_BYTES);
  localparam logic [OFF_W-1:0] EVT_STEP  = OFF_W'(EVT_BYTES);
  localparam logic [OFF_W-1:0] TX_MIN    = OFF_W'(2 * DESC_BYTES);
  localparam logic [OFF_W-1:0] EV_MIN    = OFF_W'(2 * EVT_BYTES);

  logic [OFF_W-1:0] txLen;
  logic [OFF_W-1:0] wrOff;
  logic             wrHiZero, txAlignOk, evAlignOk;
  logic             txBellOk, evBellOk, txLenOk, evLenOk;
  logic [OFF_W:0]   txSum, evSum;
  logic [OFF_W-1:0] txNext, evNext;

  // write-value legality
  always_comb begin
    wrOff     = regWrData[OFF_W-1:0];
    wrHiZero  = (regWrData[31:OFF_W] == '0);
    txAlignOk = (wrOff[DESC_LG-1:0] == '0);
    evAlignOk = (wrOff[EVT_LG-1:0] == '0);
    txBellOk  = strb.txBell && wrHiZero && txAlignOk && (wrOff < txLen);
    evBellOk  = strb.evBell && wrHiZero && evAlignOk && (wrOff < evLen);
    txLenOk   = strb.setTxLen && wrHiZero && txAlignOk && (wrOff >= TX_MIN);
    evLenOk   = strb.setEvLen && wrHiZero && evAlignOk && (wrOff >= EV_MIN);
  end

  // wrapping increments
  always_comb begin
    txSum  = {1'b0, txRdOff} + {1'b0, DESC_STEP};
    evSum  = {1'b0, evWrOff} + {1'b0, EVT_STEP};
    txNext = (txSum >= {1'b0, txLen}) ? '0 : txSum[OFF_W-1:0];
    evNext = (evSum >= {1'b0, evLen}) ? '0 : evSum[OFF_W-1:0];
    txPending = (txRdOff != txWrOff);
    evFull    = (evNext == evRdOff);
  end

  // descriptor ring pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLen   <= OFF_W'(TX_LEN_RST);
      txRdOff <= '0;
      txWrOff <= '0;
    end else if (txLenOk) begin
      txLen   <= wrOff;
      txRdOff <= '0;
      txWrOff <= '0;
    end else begin
      if (txBellOk) txWrOff <= wrOff;
      if (strb.complete) txRdOff <= txNext;
    end
  end

  // event ring pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evLen   <= OFF_W'(EV_LEN_RST);
      evWrOff <= '0;
      evRdOff <= '0;
    end else if (evLenOk) begin
      evLen   <= wrOff;
      evWrOff <= '0;
      evRdOff <= '0;
    end else begin
      if (evBellOk) evRdOff <= wrOff;
      if (strb.complete) evWrOff <= evNext;
    end
  end

  // sticky end-of-block flag, set dominates clear
  always_ff @(posedge clk) begin
    if (!rstN) eobIrq <= 1'b0;
    else if (strb.complete && doneCfg[16]) eobIrq <= 1'b1;
    else if (strb.irqClr) eobIrq <= 1'b0;
  end

  // event record
  always_comb begin
    evWrEn   = strb.complete;
    evWrAddr = evWrOff;
    evWrData = {32'h0, doneCfg, {{PAD{1'b0}}, txRdOff},
                doneCode, doneErrInfo, 8'h00, doneCfg[15:0]};
  end

  // register read mux
  always_comb begin
    unique case (regAddr)
      A_TX_RD:  regRdData = {{PAD{1'b0}}, txRdOff};
      A_TX_WR:  regRdData = {{PAD{1'b0}}, txWrOff};
      A_EV_WR:  regRdData = {{PAD{1'b0}}, evWrOff};
      A_EV_RD:  regRdData = {{PAD{1'b0}}, evRdOff};
      A_TX_LEN: regRdData = {{PAD{1'b0}}, txLen};
      A_EV_LEN: regRdData = {{PAD{1'b0}}, evLen};
      A_IRQ:    regRdData = {31'h0, eobIrq};
      default:  regRdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/dma_evt_ring_writer.sv
module dma_evt_ring_writer
  import evr_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int DESC_BYTES = 32,
  parameter int TX_SLOTS   = 8,
  parameter int EV_SLOTS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              doneValid,
  input  logic [3:0]        doneCode,
  input  logic [3:0]        doneErrInfo,
  input  logic [31:0]       doneCfg,
  output logic              doneReady,
  output logic [OFF_W-1:0]  descOffset,
  output logic              evWrEn,
  output logic [OFF_W-1:0]  evWrAddr,
  output logic [127:0]      evWrData,
  output logic              eobIrq
);

  localparam int TX_LEN_RST = DESC_BYTES * TX_SLOTS;
  localparam int EV_LEN_RST = EVT_BYTES * EV_SLOTS;

  evr_strobe_t      strb;
  logic             txPending, evFull;
  logic [OFF_W-1:0] txRdOff, txWrOff, evWrOff, evRdOff, evLen;

  evr_ctrl ctrlU (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrBit0 (regWrData[0]),
    .doneValid (doneValid),
    .txPending (txPending),
    .evFull    (evFull),
    .doneReady (doneReady),
    .strb      (strb)
  );

  evr_datapath #(
    .OFF_W      (OFF_W),
    .DESC_BYTES (DESC_BYTES),
    .TX_LEN_RST (TX_LEN_RST),
    .EV_LEN_RST (EV_LEN_RST)
  ) dpU (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .doneCode    (doneCode),
    .doneErrInfo (doneErrInfo),
    .doneCfg     (doneCfg),
    .txRdOff     (txRdOff),
    .txWrOff     (txWrOff),
    .evWrOff     (evWrOff),
    .evRdOff     (evRdOff),
    .evLen       (evLen),
    .txPending   (txPending),
    .evFull      (evFull),
    .eobIrq      (eobIrq),
    .evWrEn      (evWrEn),
    .evWrAddr    (evWrAddr),
    .evWrData    (evWrData),
    .regRdData   (regRdData)
  );

  assign descOffset = txRdOff;

endmodule

// File: rtl/dma_evt_ring_writer_chk.sv
module dma_evt_ring_writer_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             doneReady,
  input logic             cfgIeob,
  input logic             evWrEn,
  input logic [31:0]      recTxOff,
  input logic [OFF_W-1:0] txRdOff,
  input logic [OFF_W-1:0] txWrOff,
  input logic [OFF_W-1:0] evWrOff,
  input logic [OFF_W-1:0] evRdOff,
  input logic [OFF_W-1:0] evLen,
  input logic             eobIrq
);

  // R3
  ready_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneReady |-> (txRdOff != txWrOff));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWrEn |=> (evWrOff != $past(evRdOff)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneReady |-> !evWrEn);

  // R5
  ev_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWrEn |=> ((evWrOff == '0) || (evWrOff == OFF_W'($past(evWrOff) + OFF_W'(16)))));

  // R5
  ev_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evWrOff[3:0] == 4'h0) && (evWrOff < evLen));

  // R6
  rec_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWrEn |-> (recTxOff == 32'(txRdOff)));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evWrEn && cfgIeob) |=> eobIrq);

endmodule

bind dma_evt_ring_writer dma_evt_ring_writer_chk #(.OFF_W(OFF_W)) chkU (
  .clk       (clk),
  .rstN      (rstN),
  .doneReady (doneReady),
  .cfgIeob   (doneCfg[16]),
  .evWrEn    (evWrEn),
  .recTxOff  (evWrData[63:32]),
  .txRdOff   (txRdOff),
  .txWrOff   (txWrOff),
  .evWrOff   (evWrOff),
  .evRdOff   (evRdOff),
  .evLen     (evLen),
  .eobIrq    (eobIrq)
);

// File: tb/dma_evt_ring_writer_test.sv
module dma_evt_ring_writer_test;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [11:0]  regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         doneValid = 1'b0;
  logic [3:0]   doneCode = '0;
  logic [3:0]   doneErrInfo = '0;
  logic [31:0]  doneCfg = '0;
  logic         doneReady;
  logic [15:0]  descOffset;
  logic         evWrEn;
  logic [15:0]  evWrAddr;
  logic [127:0] evWrData;
  logic         eobIrq;

  int checks = 0;
  int errors = 0;

  // model state derived from the requirements
  int mTxRd, mTxWr, mEvWr, mEvRd, mTxLen, mEvLen;
  bit mIrq;

  always #(CLK_P/2) clk = ~clk;

  dma_evt_ring_writer uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneValid(doneValid),
    .doneCode(doneCode), .doneErrInfo(doneErrInfo), .doneCfg(doneCfg),
    .doneReady(doneReady), .descOffset(descOffset), .evWrEn(evWrEn),
    .evWrAddr(evWrAddr), .evWrData(evWrData), .eobIrq(eobIrq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int cur, input int unit, input int len);
    return (cur + unit >= len) ? 0 : cur + unit;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic rdChk(input logic [11:0] a, input int exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == 32'(exp), req, $sformatf("read 0x%03h", a), d, exp);
  endtask

  // one clock cycle with optional completion and optional register write
  task automatic cycleT(input bit dv, input logic [3:0] code, input logic [3:0] err,
                        input logic [31:0] cfg, input bit we, input logic [11:0] a,
                        input logic [31:0] d);
    bit expReady, acc, lenWr;
    int v;
    @(negedge clk);
    doneValid = dv; doneCode = code; doneErrInfo = err; doneCfg = cfg;
    regWrEn = we; regAddr = a; regWrData = d;
    #2;
    lenWr = we && (a == 12'h010 || a == 12'h014);
    expReady = (mTxRd != mTxWr) && (nxt(mEvWr, 16, mEvLen) != mEvRd) && !lenWr;
    acc = dv && expReady;
    chk(doneReady == expReady, "R3", "doneReady", doneReady, expReady);
    chk(descOffset == 16'(mTxRd), "R6", "descOffset", descOffset, mTxRd);
    chk(evWrEn == acc, "R7", "evWrEn", evWrEn, acc);
    if (acc) begin
      chk(evWrAddr == 16'(mEvWr), "R5", "evWrAddr", evWrAddr, mEvWr);
      chk(evWrData[31:0] == {code, err, 8'h00, cfg[15:0]}, "R4", "word0",
          evWrData[31:0], {code, err, 8'h00, cfg[15:0]});
      chk(evWrData[63:32] == 32'(mTxRd), "R6", "word1", evWrData[63:32], mTxRd);
      chk(evWrData[127:64] == {32'h0, cfg}, "R4", "word2/3", evWrData[127:64], cfg);
    end
    @(posedge clk);
    #1;
    doneValid = 1'b0; regWrEn = 1'b0;
    v = int'(d);
    if (we) begin
      if (a == 12'h400 && v % 32 == 0 && v < mTxLen && d[31:16] == 0) mTxWr = v;
      if (a == 12'h404 && v % 16 == 0 && v < mEvLen && d[31:16] == 0) mEvRd = v;
      if (a == 12'h010 && v % 32 == 0 && v >= 64 && d[31:16] == 0) begin
        mTxLen = v; mTxRd = 0; mTxWr = 0;
      end
      if (a == 12'h014 && v % 16 == 0 && v >= 32 && d[31:16] == 0) begin
        mEvLen = v; mEvWr = 0; mEvRd = 0;
      end
      if (a == 12'h024 && d[0]) mIrq = 1'b0;
    end
    if (acc) begin
      mTxRd = nxt(mTxRd, 32, mTxLen);
      mEvWr = nxt(mEvWr, 16, mEvLen);
      if (cfg[16]) mIrq = 1'b1;
    end
  endtask

  task automatic regWr(input logic [11:0] a, input logic [31:0] d);
    cycleT(1'b0, 4'h0, 4'h0, 32'h0, 1'b1, a, d);
  endtask

  task automatic compl(input logic [3:0] code, input logic [3:0] err, input logic [31:0] cfg);
    cycleT(1'b1, code, err, cfg, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic checkAll(input string req);
    rdChk(12'h000, mTxRd, req);
    rdChk(12'h004, mTxWr, req);
    rdChk(12'h008, mEvWr, req);
    rdChk(12'h00C, mEvRd, req);
    rdChk(12'h010, mTxLen, req);
    rdChk(12'h014, mEvLen, req);
    rdChk(12'h020, int'(mIrq), req);
    chk(eobIrq == mIrq, req, "eobIrq", eobIrq, mIrq);
  endtask

  task automatic testReset;
    mTxRd = 0; mTxWr = 0; mEvWr = 0; mEvRd = 0; mTxLen = 256; mEvLen = 128; mIrq = 0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 literal reset values
    rdChk(12'h010, 256, "R1");
    rdChk(12'h014, 128, "R1");
    chk(doneReady == 1'b0, "R1", "doneReady", doneReady, 0);
    chk(eobIrq == 1'b0, "R1", "eobIrq", eobIrq, 0);
    checkAll("R1");
  endtask

  task automatic testTxBell;
    regWr(12'h400, 32'h30);      // R2 misaligned
    rdChk(12'h004, 0, "R2");
    regWr(12'h400, 32'h100);     // R2 equals length
    rdChk(12'h004, 0, "R2");
    regWr(12'h400, 32'h60);      // R2 legal, three descriptors
    rdChk(12'h004, 32'h60, "R2");
    chk(doneReady == 1'b1, "R3", "doneReady after post", doneReady, 1);
  endtask

  task automatic testInOrder;
    compl(4'h1, 4'h0, 32'h0000_5A03);          // R4 copy, no interrupt request
    chk(eobIrq == 1'b0, "R9", "irq without request", eobIrq, 0);
    compl(4'h1, 4'h0, 32'h0001_5A03);          // R9 interrupt request
    chk(eobIrq == 1'b1, "R9", "irq set", eobIrq, 1);
    compl(4'h4, 4'hA, 32'h0000_5A04);          // R4 error code, fill type
    checkAll("R6");
    rdChk(12'h000, 32'h60, "R5");
  endtask

  task automatic testIdleIgnore;
    compl(4'h1, 4'h0, 32'h0001_0003);          // R3 nothing pending
    rdChk(12'h000, 32'h60, "R3");
    rdChk(12'h008, 32'h30, "R3");
    checkAll("R3");
  endtask

  task automatic testIrq;
    regWr(12'h024, 32'h1);                     // R9 clear
    chk(eobIrq == 1'b0, "R9", "irq cleared", eobIrq, 0);
    regWr(12'h400, 32'h20);                    // wrap post: six pending
    cycleT(1'b1, 4'h1, 4'h0, 32'h0001_0103, 1'b1, 12'h024, 32'h1);
    chk(eobIrq == 1'b1, "R9", "set wins over clear", eobIrq, 1);
    checkAll("R9");
  endtask

  task automatic testStall;
    for (int i = 0; i < 3; i++) compl(4'h1, 4'(i), 32'h0000_0203);
    // R7 event ring full with descriptors pending
    chk(doneReady == 1'b0, "R7", "doneReady when full", doneReady, 0);
    compl(4'h1, 4'h0, 32'h0001_0203);
    rdChk(12'h008, 32'h70, "R7");
    rdChk(12'h000, 32'hE0, "R7");
    chk(eobIrq == 1'b1, "R7", "irq untouched", eobIrq, 1);
    checkAll("R7");
  endtask

  task automatic testEvBell;
    regWr(12'h404, 32'h18);                    // R8 misaligned
    rdChk(12'h00C, 0, "R8");
    regWr(12'h404, 32'h80);                    // R8 equals length
    rdChk(12'h00C, 0, "R8");
    regWr(12'h404, 32'h40);
    rdChk(12'h00C, 32'h40, "R8");
    chk(doneReady == 1'b1, "R8", "space reopened", doneReady, 1);
    compl(4'h1, 4'h0, 32'h0000_0303);
    rdChk(12'h008, 0, "R5");                   // event offset wrapped
    rdChk(12'h000, 0, "R5");                   // descriptor offset wrapped
    cycleT(1'b1, 4'h1, 4'h0, 32'h0000_0303, 1'b1, 12'h404, 32'h50);
    rdChk(12'h008, 32'h10, "R8");
    rdChk(12'h00C, 32'h50, "R8");
    checkAll("R8");
  endtask

  task automatic testLen;
    regWr(12'h014, 32'h18);                    // R10 misaligned
    rdChk(12'h014, 128, "R10");
    regWr(12'h014, 32'h10);                    // R10 below two entries
    rdChk(12'h014, 128, "R10");
    regWr(12'h014, 32'h40);
    rdChk(12'h014, 32'h40, "R10");
    rdChk(12'h008, 0, "R10");
    rdChk(12'h00C, 0, "R10");
    regWr(12'h010, 32'h80);
    rdChk(12'h010, 32'h80, "R10");
    rdChk(12'h000, 0, "R10");
    regWr(12'h400, 32'h20);
    cycleT(1'b1, 4'h1, 4'h0, 32'h0000_0403, 1'b1, 12'h010, 32'h20); // refused, bad length
    rdChk(12'h008, 0, "R10");
    compl(4'h1, 4'h0, 32'h0000_0403);
    rdChk(12'h008, 32'h10, "R10");
    checkAll("R10");
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testTxBell();
    testInOrder();
    testIdleIgnore();
    testIrq();
    testStall();
    testEvBell();
    testLen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule